// File: doc/BRIEF.md
# Multi-Track Sector Address Sequencer

This block walks the sector address of a multi-sector disc transfer. A load strobe gives it the starting cylinder, head, record and size code, the last record number on the track and the command byte that carries the multi-track flag. From then on it asks the drive side for each sector in turn. It counts the data bytes of the current sector and, at each sector boundary, either moves to the next record or wraps the track. The wrap ends the transfer, or, in multi-track mode, carries it over to the second side.

The transfer ends in one of three ways: at the end of the cylinder, on a terminal-count input, or on a "sector not found" reply from the drive side. Each ending gives a single-cycle done pulse. The final address stays on the outputs until the next load, so a controller can report it in its result bytes.

Top module: `sector_walk`

## Requirements
- R1: After reset, busy, sec_req, done, end_cyl and no_data are 0, and cur_cyl, cur_head, cur_rec and cur_size are 0.
- R2: A load captures cyl/head/rec/size/last. In the next cycle, busy is 1, sec_req pulses for one cycle and the end_cyl and no_data flags are 0. A load takes priority over every other input.
- R3: A sector holds 128 << size bytes for size codes 0 to 7, and 16384 bytes for any size code above 7. The sector boundary is taken on the byte strobe that brings the count to that length.
- R4: At a boundary with cur_rec below the last record, cur_rec increments by 1, head and cylinder stay the same, and sec_req pulses for the next sector.
- R5: At a boundary with cur_rec at or above the last record and the multi-track flag clear, cur_rec becomes 1, the head is unchanged, cur_cyl increments, end_cyl is set and done pulses.
- R6: At that wrap with the multi-track flag set, bit 0 of the head toggles and cur_rec becomes 1. If the head value is then non-zero, the transfer continues and sec_req pulses for sector 1 on the new side.
- R7: At that wrap with the multi-track flag set, if the head value is 0 after the toggle, cur_cyl increments, end_cyl is set and done pulses.
- R8: A terminal-count strobe during a transfer ends it. Done pulses in the next cycle, the address does not change and end_cyl stays 0.
- R9: A drive reply with rsp_notfound=1 while a sector request is outstanding ends the transfer. Done pulses, no_data is set and the address does not change.
- R10: Byte strobes are ignored while a sector request is outstanding and while idle. They do not count toward the sector length and do not change the address.
- R11: While idle, cur_cyl, cur_head, cur_rec and cur_size hold their values until the next load.
- R12: The multi-track flag is bit 7 of the ld_cmd byte.
- R13: Done is a single-cycle pulse and never coincides with sec_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a transfer with the ld_* values |
| ld_cmd | input | 8 | Command byte; bit 7 is the multi-track flag |
| ld_cyl | input | 8 | Starting cylinder |
| ld_head | input | 8 | Starting head value |
| ld_rec | input | 8 | Starting record (sector number) |
| ld_size | input | 8 | Sector size code |
| ld_last | input | 8 | Last record number on the track |
| byte_stb | input | 1 | One data byte transferred |
| term_cnt | input | 1 | Terminal count: end the transfer now |
| rsp_valid | input | 1 | Drive-side reply to a sector request |
| rsp_notfound | input | 1 | The reply reports the sector as not found |
| cur_cyl | output | 8 | Current cylinder |
| cur_head | output | 8 | Current head value |
| cur_rec | output | 8 | Current record |
| cur_size | output | 8 | Current size code |
| busy | output | 1 | A transfer is in progress |
| sec_req | output | 1 | Pulse: request the sector at the current address |
| end_cyl | output | 1 | The transfer ended at the end of the cylinder |
| no_data | output | 1 | The transfer ended because a sector was not found |
| done | output | 1 | Pulse: the transfer has ended |

## Verification
The bound assertions check the following on every cycle: the start of a transfer after a load, the shape of the done pulse and its exclusion with sec_req, an unmoved address after a terminal count, an address held while idle, and the end_cyl and no_data flags rising only with done. Only the bench scenarios can show the arithmetic of the walk. That covers the exact byte count per size code including the 16384-byte cap, the record increment, the head flip to side 1 and the wrap back to side 0, and the cylinder increment at the end of the cylinder. The scoreboard also shows that strobes arriving before the drive reply are not counted.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } sw_state_e;

endpackage

// File: rtl/sw_byte_count.sv
module sw_byte_count #(
  parameter int BASE_LOG2 = 7,
  parameter int MAX_SHIFT = 7,
  parameter int CODE_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic [CODE_W-1:0] size_code,
  output logic              at_last
);
  localparam int CNT_W  = BASE_LOG2 + MAX_SHIFT;
  localparam int N_SIZE = MAX_SHIFT + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_tab [N_SIZE];
  logic [CNT_W-1:0] limit;

  // One byte-count limit per size code: (base << k) - 1
  genvar g;
  generate
    for (g = 0; g < N_SIZE; g++) begin : g_lim
      assign lim_tab[g] = CNT_W'((CNT_W+1)'(1) << (BASE_LOG2 + g)) - CNT_W'(1);
    end
  endgenerate

  always_comb begin
    limit = lim_tab[MAX_SHIFT];          // codes above the cap use the largest size
    for (int k = 0; k < N_SIZE; k++) begin
      if (size_code == CODE_W'(k)) limit = lim_tab[k];
    end
  end

  assign at_last = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= at_last ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sw_addr_step.sv
module sw_addr_step #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] cyl,
  input  logic [AW-1:0] head,
  input  logic [AW-1:0] rec,
  input  logic [AW-1:0] last_rec,
  input  logic          multi,
  output logic [AW-1:0] nxt_cyl,
  output logic [AW-1:0] nxt_head,
  output logic [AW-1:0] nxt_rec,
  output logic          finish
);
  logic [AW-1:0] head_t;

  always_comb begin
    head_t   = multi ? (head ^ AW'(1)) : head;
    nxt_cyl  = cyl;
    nxt_head = head;
    nxt_rec  = rec;
    finish   = 1'b0;
    if (rec < last_rec) begin
      nxt_rec = rec + AW'(1);
    end else begin
      nxt_rec  = AW'(1);
      nxt_head = head_t;
      if (!multi || (head_t == '0)) begin
        nxt_cyl = cyl + AW'(1);
        finish  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sector_walk.sv
module sector_walk #(
  parameter int AW        = 8,
  parameter int BASE_LOG2 = 7,
  parameter int MAX_SHIFT = 7,
  parameter int MT_BIT    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [7:0]    ld_cmd,
  input  logic [AW-1:0] ld_cyl,
  input  logic [AW-1:0] ld_head,
  input  logic [AW-1:0] ld_rec,
  input  logic [AW-1:0] ld_size,
  input  logic [AW-1:0] ld_last,
  input  logic          byte_stb,
  input  logic          term_cnt,
  input  logic          rsp_valid,
  input  logic          rsp_notfound,
  output logic [AW-1:0] cur_cyl,
  output logic [AW-1:0] cur_head,
  output logic [AW-1:0] cur_rec,
  output logic [AW-1:0] cur_size,
  output logic          busy,
  output logic          sec_req,
  output logic          end_cyl,
  output logic          no_data,
  output logic          done
);
  import sw_pkg::*;

  sw_state_e     state;
  logic [AW-1:0] last_r;
  logic          multi_r;
  logic          at_last;
  logic          cnt_inc;
  logic          boundary;
  logic [AW-1:0] n_cyl, n_head, n_rec;
  logic          n_finish;

  assign cnt_inc  = (state == ST_XFER) && byte_stb && !term_cnt && !load;
  assign boundary = cnt_inc && at_last;

  sw_byte_count #(
    .BASE_LOG2 (BASE_LOG2),
    .MAX_SHIFT (MAX_SHIFT),
    .CODE_W    (AW)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr       (load),
    .inc       (cnt_inc),
    .size_code (cur_size),
    .at_last   (at_last)
  );

  sw_addr_step #(.AW(AW)) u_step (
    .cyl      (cur_cyl),
    .head     (cur_head),
    .rec      (cur_rec),
    .last_rec (last_r),
    .multi    (multi_r),
    .nxt_cyl  (n_cyl),
    .nxt_head (n_head),
    .nxt_rec  (n_rec),
    .finish   (n_finish)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_cyl  <= '0;
      cur_head <= '0;
      cur_rec  <= '0;
      cur_size <= '0;
      last_r   <= '0;
      multi_r  <= 1'b0;
      sec_req  <= 1'b0;
      done     <= 1'b0;
      end_cyl  <= 1'b0;
      no_data  <= 1'b0;
    end else begin
      sec_req <= 1'b0;
      done    <= 1'b0;
      if (load) begin
        cur_cyl  <= ld_cyl;
        cur_head <= ld_head;
        cur_rec  <= ld_rec;
        cur_size <= ld_size;
        last_r   <= ld_last;
        multi_r  <= ld_cmd[MT_BIT];
        end_cyl  <= 1'b0;
        no_data  <= 1'b0;
        sec_req  <= 1'b1;
        state    <= ST_WAIT;
      end else begin
        unique case (state)
          ST_WAIT: begin
            if (term_cnt) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else if (rsp_valid) begin
              if (rsp_notfound) begin
                no_data <= 1'b1;
                done    <= 1'b1;
                state   <= ST_IDLE;
              end else begin
                state <= ST_XFER;
              end
            end
          end
          ST_XFER: begin
            if (term_cnt) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else if (boundary) begin
              cur_cyl  <= n_cyl;
              cur_head <= n_head;
              cur_rec  <= n_rec;
              if (n_finish) begin
                end_cyl <= 1'b1;
                done    <= 1'b1;
                state   <= ST_IDLE;
              end else begin
                sec_req <= 1'b1;
                state   <= ST_WAIT;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sector_walk_chk.sv
module sector_walk_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic          term_cnt,
  input logic [AW-1:0] cur_cyl,
  input logic [AW-1:0] cur_head,
  input logic [AW-1:0] cur_rec,
  input logic [AW-1:0] cur_size,
  input logic          busy,
  input logic          sec_req,
  input logic          end_cyl,
  input logic          no_data,
  input logic          done
);

  p_load_starts_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (sec_req && busy && !done && !end_cyl && !no_data));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_req_done_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(sec_req && done));

  p_tc_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && term_cnt && !load) |=>
      (done && !busy && !end_cyl && $stable(cur_cyl) && $stable(cur_head) && $stable(cur_rec)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=>
      ($stable(cur_cyl) && $stable(cur_head) && $stable(cur_rec) && $stable(cur_size) && !sec_req));

  p_endcyl_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(end_cyl) |-> (done && !busy));

  p_nodata_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(no_data) |-> (done && !end_cyl));

endmodule

bind sector_walk sector_walk_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .term_cnt (term_cnt),
  .cur_cyl  (cur_cyl),
  .cur_head (cur_head),
  .cur_rec  (cur_rec),
  .cur_size (cur_size),
  .busy     (busy),
  .sec_req  (sec_req),
  .end_cyl  (end_cyl),
  .no_data  (no_data),
  .done     (done)
);

// File: tb/sector_walk_tb_top.sv
`timescale 1ns/1ps
module sector_walk_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [7:0] ld_cmd = '0, ld_cyl = '0, ld_head = '0, ld_rec = '0, ld_size = '0, ld_last = '0;
  logic       byte_stb = 1'b0, term_cnt = 1'b0, rsp_valid = 1'b0, rsp_notfound = 1'b0;
  logic [7:0] cur_cyl, cur_head, cur_rec, cur_size;
  logic       busy, sec_req, end_cyl, no_data, done;

  always #2.5 clk = ~clk;   // 200 MHz

  sector_walk dut_i (.*);

  int n_checks = 0;
  int n_fails  = 0;

  // scoreboard item: kind 0 = sector request, 1 = done
  typedef struct packed {
    logic       kind;
    logic [7:0] c;
    logic [7:0] h;
    logic [7:0] r;
    logic       endc;
    logic       nod;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // bench model of the address walk
  logic [7:0] m_c, m_h, m_r, m_last, m_n;
  logic       m_mt;

  function automatic void push_exp(logic kind, logic endc, logic nod, string tag);
    exp_t e;
    e.kind = kind; e.c = m_c; e.h = m_h; e.r = m_r; e.endc = endc; e.nod = nod;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endfunction

  task automatic check(bit ok, string tag, string msg);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // monitor: pop and compare on every event
  always @(negedge clk) begin
    if (!rst && (sec_req || done)) begin
      exp_t e;
      string t;
      if (exp_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL R13 unexpected event req=%0b done=%0b at c=%0d h=%0d r=%0d, expected none",
                 sec_req, done, cur_cyl, cur_head, cur_rec);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (e.kind == 1'b0) begin
          if (!(sec_req && !done && cur_cyl == e.c && cur_head == e.h && cur_rec == e.r)) begin
            n_fails++;
            $display("FAIL %s req: actual req=%0b done=%0b c=%0d h=%0d r=%0d expected req c=%0d h=%0d r=%0d",
                     t, sec_req, done, cur_cyl, cur_head, cur_rec, e.c, e.h, e.r);
          end
        end else begin
          if (!(done && !sec_req && !busy && cur_cyl == e.c && cur_head == e.h && cur_rec == e.r &&
                end_cyl == e.endc && no_data == e.nod)) begin
            n_fails++;
            $display("FAIL %s done: actual done=%0b c=%0d h=%0d r=%0d endc=%0b nod=%0b expected c=%0d h=%0d r=%0d endc=%0b nod=%0b",
                     t, done, cur_cyl, cur_head, cur_rec, end_cyl, no_data, e.c, e.h, e.r, e.endc, e.nod);
          end
        end
      end
    end
  end

  task automatic do_load(logic [7:0] cmd, logic [7:0] c, logic [7:0] h, logic [7:0] r,
                         logic [7:0] n, logic [7:0] last, string tag);
    m_c = c; m_h = h; m_r = r; m_n = n; m_last = last; m_mt = cmd[7];
    push_exp(1'b0, 1'b0, 1'b0, tag);
    @(negedge clk);
    load = 1'b1; ld_cmd = cmd; ld_cyl = c; ld_head = h; ld_rec = r; ld_size = n; ld_last = last;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic send_bytes(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      byte_stb = 1'b1;
    end
    @(negedge clk);
    byte_stb = 1'b0;
  endtask

  task automatic ack(logic nf, string tag);
    if (nf) push_exp(1'b1, 1'b0, 1'b1, tag);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_notfound = nf;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_notfound = 1'b0;
  endtask

  // one full sector; returns 1 when the transfer continues
  task automatic run_sector(string tag, output bit more);
    int   sz;
    logic fin;
    logic [7:0] th;
    sz = (m_n > 8'd7) ? 16384 : (128 << m_n);
    send_bytes(sz - 1);          // no event may appear before the last byte
    fin = 1'b0;
    if (m_r < m_last) begin
      m_r = m_r + 8'd1;
    end else begin
      m_r = 8'd1;
      th  = m_mt ? (m_h ^ 8'd1) : m_h;
      m_h = th;
      if (!m_mt || th == 8'd0) begin
        m_c = m_c + 8'd1;
        fin = 1'b1;
      end
    end
    push_exp(fin, fin, 1'b0, tag);
    send_bytes(1);
    more = !fin;
    if (!fin) ack(1'b0, tag);
  endtask

  task automatic drain(int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    bit more;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !sec_req && !done && !end_cyl && !no_data, "R1",
          $sformatf("flags busy=%0b req=%0b done=%0b endc=%0b nod=%0b expected all 0",
                    busy, sec_req, done, end_cyl, no_data));
    check(cur_cyl == 0 && cur_head == 0 && cur_rec == 0 && cur_size == 0, "R1",
          $sformatf("addr %0d/%0d/%0d/%0d expected 0/0/0/0", cur_cyl, cur_head, cur_rec, cur_size));

    // single side, size code 0, records 1..3; strobes before the reply ignored (R10)
    do_load(8'h46, 8'd5, 8'd0, 8'd1, 8'd0, 8'd3, "R2");
    check(busy, "R2", $sformatf("busy=%0b expected 1", busy));
    send_bytes(5);               // R10: ignored while waiting for reply
    ack(1'b0, "R10");
    run_sector("R4", more);
    run_sector("R4", more);
    run_sector("R5", more);
    check(end_cyl && !no_data, "R5", $sformatf("endc=%0b nod=%0b expected 1 0", end_cyl, no_data));
    // R10/R11: idle strobes change nothing
    send_bytes(20);
    drain(3);
    check(!busy && cur_cyl == 8'd6 && cur_head == 8'd0 && cur_rec == 8'd1 && cur_size == 8'd0, "R11",
          $sformatf("idle addr %0d/%0d/%0d/%0d busy=%0b expected 6/0/1/0 0",
                    cur_cyl, cur_head, cur_rec, cur_size, busy));

    // multi-track (bit 7 of ld_cmd), size code 1: side 0 -> side 1 -> end
    do_load(8'hC6, 8'd2, 8'd0, 8'd2, 8'd1, 8'd2, "R12");
    ack(1'b0, "R2");
    run_sector("R6", more);
    check(more && cur_head == 8'd1, "R6", $sformatf("head=%0d expected 1", cur_head));
    run_sector("R4", more);
    run_sector("R7", more);
    check(end_cyl, "R7", $sformatf("endc=%0b expected 1", end_cyl));

    // multi-track starting on side 1 ends after one sector
    do_load(8'hC5, 8'd7, 8'd1, 8'd1, 8'd0, 8'd1, "R2");
    ack(1'b0, "R2");
    run_sector("R7", more);
    check(cur_head == 8'd0 && cur_cyl == 8'd8, "R7",
          $sformatf("c=%0d h=%0d expected 8 0", cur_cyl, cur_head));

    // terminal count mid-sector
    do_load(8'h46, 8'd9, 8'd0, 8'd4, 8'd2, 8'd8, "R2");
    ack(1'b0, "R2");
    send_bytes(100);
    push_exp(1'b1, 1'b0, 1'b0, "R8");
    @(negedge clk); term_cnt = 1'b1;
    @(negedge clk); term_cnt = 1'b0;
    check(!end_cyl && cur_rec == 8'd4, "R8", $sformatf("endc=%0b r=%0d expected 0 4", end_cyl, cur_rec));

    // sector not found
    do_load(8'h45, 8'd3, 8'd0, 8'd9, 8'd1, 8'd9, "R2");
    ack(1'b1, "R9");
    check(no_data && !end_cyl, "R9", $sformatf("nod=%0b endc=%0b expected 1 0", no_data, end_cyl));

    // load clears flags left by the previous transfer
    do_load(8'h46, 8'd1, 8'd0, 8'd1, 8'd9, 8'd1, "R2");
    check(!no_data && !end_cyl, "R2", $sformatf("nod=%0b endc=%0b expected 0 0", no_data, end_cyl));
    ack(1'b0, "R2");
    // size code 9 is capped at 16384 bytes
    run_sector("R3", more);

    drain(5);
    check(exp_q.size() == 0, "R13", $sformatf("pending=%0d expected 0", exp_q.size()));
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule